// File: doc/BRIEF.md
# Base-Mask Address Routing Decoder

This block holds a bank of programmable routing descriptors and decides, for every incoming memory request, which of eight destination ports should receive it. Each descriptor carries a 3-bit destination code, a special-cycle compare bit, a 20-bit page base and a 20-bit page mask. A request supplies a 32-bit physical address and a flag that marks special cycles such as halt or shutdown. The block compares the page number of the address (bits 31:12) against every descriptor in parallel. It then reports whether any descriptor hit, which one won and the port it names.

Software programs the descriptors through a simple register port. Descriptor `i` lives at register address `REG_BASE + i`. After reset every descriptor is set so that it can never hit. A request that matches nothing is reported as a miss and is steered to a parameterized default port. The number of descriptors is a parameter, so the same block serves a small six-entry router and a larger ten-entry one.

Top module: `addr_route_decoder`

## Requirements
- R1: After reset every descriptor reads back as 0x000000FF_FFF00000. That value means destination 0, compare bit 0, base 0xFFFFF and mask 0x00000, and no request can hit a descriptor in this state.
- R2: A descriptor matches when (req_addr_i[31:12] & mask) equals its base. The 64-bit word places the mask in bits 19:0 and the base in bits 39:20.
- R3: A match also requires req_special_i to equal the descriptor's compare bit (bit 60). A descriptor with bit 60 = 0 hits only normal cycles, and one with bit 60 = 1 hits only special cycles.
- R4: On a hit, port_o equals the winning descriptor's destination code (bits 63:61) and idx_o equals its index.
- R5: When several descriptors match, the one with the lowest index wins.
- R6: When nothing matches, hit_o is 0, idx_o is 0 and port_o equals DEFAULT_PORT.
- R7: rsp_valid_o is high exactly one cycle after req_valid_i, and hit_o, idx_o and port_o update only in that cycle.
- R8: A descriptor write changes the routing of requests presented in later cycles. A request presented in the same cycle as the write is routed by the old contents.
- R9: Bits 59:40 of every descriptor always read as zero, and values written to those bits are discarded.
- R10: A read at an address outside REG_BASE to REG_BASE+NUM_DESC-1 returns zero and sets reg_err_o. A write to such an address changes no descriptor.
- R11: reg_rvalid_o, reg_rdata_o and reg_err_o report a read one cycle after reg_re_i. reg_err_o is 0 for reads inside the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Descriptor write strobe |
| reg_re_i | input | 1 | Descriptor read strobe |
| reg_addr_i | input | REG_AW | Register address |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data |
| reg_rvalid_o | output | 1 | Read data valid |
| reg_err_o | output | 1 | Read address out of range |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | 32 | Request physical address |
| req_special_i | input | 1 | Request is a special cycle |
| rsp_valid_o | output | 1 | Routing result valid |
| hit_o | output | 1 | A descriptor matched |
| idx_o | output | IDX_W | Winning descriptor index |
| port_o | output | 3 | Destination port |

## Verification
The hardest case to reach from the ports is a write and a request in the same cycle, where the request must still see the old descriptor. The bench first sets up two overlapping descriptors, so that the lower one wins. It then disables the lower descriptor and re-enables it in the same cycle that a request arrives, and expects the higher descriptor to win that request and the lower one to win the next. Priority and the special-cycle compare are checked by programming overlapping ranges that differ only in the compare bit.

// File: rtl/addr_route_pkg.sv
package addr_route_pkg;
  localparam int PAGE_W = 20;
  localparam int PORT_W = 3;

  typedef struct packed {
    logic [PORT_W-1:0] dst;
    logic              spc;
    logic [PAGE_W-1:0] base;
    logic [PAGE_W-1:0] mask;
  } desc_t;

  localparam desc_t DESC_RST = '{dst: 3'd0, spc: 1'b0, base: 20'hFFFFF, mask: 20'h00000};

  function automatic logic [63:0] desc_to_word(desc_t d);
    return {d.dst, d.spc, 20'h00000, d.base, d.mask};
  endfunction
endpackage

// File: rtl/route_desc_bank.sv
module route_desc_bank
  import addr_route_pkg::*;
#(
  parameter int NUM_DESC = 6,
  parameter int REG_AW   = 8,
  parameter int REG_BASE = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic                reg_re_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [63:0]         reg_wdata_i,
  output logic [63:0]         reg_rdata_o,
  output logic                reg_rvalid_o,
  output logic                reg_err_o,
  output desc_t [NUM_DESC-1:0] desc_o
);
  localparam logic [REG_AW-1:0] BASE_L = REG_BASE[REG_AW-1:0];
  localparam logic [REG_AW:0]   NUM_L  = NUM_DESC[REG_AW:0];

  logic [REG_AW-1:0] off;
  logic              in_rng;
  desc_t             wdesc;
  logic [19:0]       wr_rsvd_unused;
  logic [63:0]       rd_sel;
  desc_t [NUM_DESC-1:0] desc_q;

  assign off    = reg_addr_i - BASE_L;
  assign in_rng = (reg_addr_i >= BASE_L) && ({1'b0, off} < NUM_L);

  // reserved field is dropped on the way in
  assign wr_rsvd_unused = reg_wdata_i[59:40];
  assign wdesc = '{dst: reg_wdata_i[63:61], spc: reg_wdata_i[60],
                   base: reg_wdata_i[39:20], mask: reg_wdata_i[19:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_DESC; i++) desc_q[i] <= DESC_RST;
    end else if (reg_we_i && in_rng) begin
      for (int i = 0; i < NUM_DESC; i++)
        if (off == REG_AW'(i)) desc_q[i] <= wdesc;
    end
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_DESC; i++)
      if (in_rng && off == REG_AW'(i)) rd_sel = desc_to_word(desc_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rdata_o  <= '0;
      reg_rvalid_o <= 1'b0;
      reg_err_o    <= 1'b0;
    end else begin
      reg_rvalid_o <= reg_re_i;
      if (reg_re_i) begin
        reg_rdata_o <= rd_sel;
        reg_err_o   <= !in_rng;
      end else begin
        reg_err_o   <= 1'b0;
      end
    end
  end

  assign desc_o = desc_q;

  p_rd_lat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_i |=> reg_rvalid_o);
  p_err_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_err_o |-> (reg_rvalid_o && reg_rdata_o == 64'd0));
  p_oor_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && !in_rng) |=> reg_err_o);
endmodule

// File: rtl/route_match.sv
module route_match
  import addr_route_pkg::*;
(
  input  desc_t             desc_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              spc_i,
  output logic              hit_o
);
  assign hit_o = ((page_i & desc_i.mask) == desc_i.base) && (spc_i == desc_i.spc);
endmodule

// File: rtl/route_prio.sv
module route_prio #(
  parameter int N     = 6,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     grant_o
);
  // scan downward so the lowest set index is the last one written
  always_comb begin
    idx_o   = '0;
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o   = IDX_W'(i);
        grant_o = '0;
        grant_o[i] = 1'b1;
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/addr_route_decoder.sv
module addr_route_decoder
  import addr_route_pkg::*;
#(
  parameter int NUM_DESC     = 6,
  parameter int REG_AW       = 8,
  parameter int REG_BASE     = 32,
  parameter int DEFAULT_PORT = 0,
  localparam int IDX_W       = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  output logic              reg_rvalid_o,
  output logic              reg_err_o,
  input  logic              req_valid_i,
  input  logic [31:0]       req_addr_i,
  input  logic              req_special_i,
  output logic              rsp_valid_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [2:0]        port_o
);
  localparam logic [PORT_W-1:0] DFLT = DEFAULT_PORT[PORT_W-1:0];

  desc_t [NUM_DESC-1:0] desc;
  logic  [NUM_DESC-1:0] hits;
  logic  [NUM_DESC-1:0] grant;
  logic                 any_hit;
  logic [IDX_W-1:0]     win_idx;
  logic [PORT_W-1:0]    win_port;
  logic [11:0]          addr_lo_unused;

  assign addr_lo_unused = req_addr_i[11:0];

  route_desc_bank #(
    .NUM_DESC(NUM_DESC), .REG_AW(REG_AW), .REG_BASE(REG_BASE)
  ) u_bank (
    .clk_i, .rst_ni, .reg_we_i, .reg_re_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .reg_rvalid_o, .reg_err_o, .desc_o(desc)
  );

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_match
    route_match u_match (
      .desc_i(desc[g]), .page_i(req_addr_i[31:12]),
      .spc_i(req_special_i), .hit_o(hits[g])
    );
  end

  route_prio #(.N(NUM_DESC), .IDX_W(IDX_W)) u_prio (
    .req_i(hits), .any_o(any_hit), .idx_o(win_idx), .grant_o(grant)
  );

  always_comb begin
    win_port = DFLT;
    for (int i = 0; i < NUM_DESC; i++)
      if (grant[i]) win_port = desc[i].dst;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      idx_o       <= '0;
      port_o      <= DFLT;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        hit_o  <= any_hit;
        idx_o  <= win_idx;
        port_o <= win_port;
      end
    end
  end

  p_rsp_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_rsp_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && $stable(port_o) && $stable(hit_o)));
  p_miss_dflt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !hit_o) |-> (port_o == DFLT && idx_o == '0));
  p_grant_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && (any_hit == (grant != '0)));
endmodule

// File: tb/sim_addr_route_decoder.sv
module sim_addr_route_decoder;
  localparam int N     = 10;
  localparam int AW    = 8;
  localparam int RB    = 32;
  localparam int DP    = 7;
  localparam int IW    = 4;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, reg_re = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic reg_rvalid, reg_err;
  logic req_valid = 0, req_special = 0;
  logic [31:0] req_addr = '0;
  logic rsp_valid, hit;
  logic [IW-1:0] idx;
  logic [2:0] port;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [2:0]  m_dst  [N];
  logic        m_spc  [N];
  logic [19:0] m_base [N];
  logic [19:0] m_mask [N];

  always #2.5 clk = ~clk;

  addr_route_decoder #(.NUM_DESC(N), .REG_AW(AW), .REG_BASE(RB), .DEFAULT_PORT(DP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .reg_rvalid_o(reg_rvalid), .reg_err_o(reg_err), .req_valid_i(req_valid),
    .req_addr_i(req_addr), .req_special_i(req_special), .rsp_valid_o(rsp_valid),
    .hit_o(hit), .idx_o(idx), .port_o(port)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [2:0] d, input logic s, input logic [19:0] b, input logic [19:0] m);
    return {d, s, 20'h0, b, m};
  endfunction

  // model of the routing decision
  task automatic expect_route(input logic [31:0] a, input logic s,
                              output logic eh, output logic [IW-1:0] ei, output logic [2:0] ep);
    eh = 0; ei = '0; ep = 3'(DP);
    for (int i = N - 1; i >= 0; i--)
      if (((a[31:12] & m_mask[i]) == m_base[i]) && (s == m_spc[i])) begin
        eh = 1; ei = IW'(i); ep = m_dst[i];
      end
  endtask

  task automatic wr(input int i, input logic [63:0] w);
    @(negedge clk);
    reg_we = 1; reg_addr = AW'(RB + i); reg_wdata = w;
    @(negedge clk);
    reg_we = 0;
    if (i >= 0 && i < N) begin
      m_dst[i] = w[63:61]; m_spc[i] = w[60]; m_base[i] = w[39:20]; m_mask[i] = w[19:0];
    end
  endtask

  task automatic rd(input int a, input logic [63:0] exp, input logic eerr, input string tag);
    @(negedge clk);
    reg_re = 1; reg_addr = AW'(a);
    @(negedge clk);
    reg_re = 0;
    chk({tag, " rvalid"}, 64'(reg_rvalid), 64'd1);
    chk({tag, " rdata"}, reg_rdata, exp);
    chk({tag, " err"}, 64'(reg_err), 64'(eerr));
  endtask

  task automatic route(input logic [31:0] a, input logic s, input string tag);
    logic eh; logic [IW-1:0] ei; logic [2:0] ep;
    expect_route(a, s, eh, ei, ep);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_special = s;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " hit"}, 64'(hit), 64'(eh));
    chk({tag, " idx"}, 64'(idx), 64'(ei));
    chk({tag, " port"}, 64'(port), 64'(ep));
  endtask

  task automatic t_reset;
    chk("R1 hit after reset", 64'(hit), 64'd0);
    chk("R7 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    rd(RB, 64'h000000FF_FFF00000, 0, "R1 desc0 reset");
    rd(RB + N - 1, 64'h000000FF_FFF00000, 0, "R1 last desc reset");
    route(32'h0000_0000, 0, "R1 R6 reset miss");
    route(32'hFFFF_F000, 0, "R1 R6 reset miss ones");
  endtask

  task automatic t_rsvd;
    wr(2, 64'h0AAAAAFF_FFF00000 | 64'hA000_0000_0000_0000);
    rd(RB + 2, mk(3'd5, 0, 20'hFFFFF, 20'h00000), 0, "R9 rsvd discarded");
  endtask

  task automatic t_match;
    wr(2, mk(3'd5, 0, 20'h12340, 20'hFFFF0));
    rd(RB + 2, mk(3'd5, 0, 20'h12340, 20'hFFFF0), 0, "R10 readback at base+2");
    route(32'h1234_5678, 0, "R2 R4 hit");
    route(32'h1234_0000, 0, "R2 hit masked low page");
    route(32'h1235_0000, 0, "R2 miss outside mask");
  endtask

  task automatic t_special;
    route(32'h1234_5678, 1, "R3 special blocks normal desc");
    wr(4, mk(3'd6, 1, 20'h00000, 20'h00000));
    route(32'hFFFF_F000, 1, "R3 special desc hit");
    route(32'hFFFF_F000, 0, "R3 normal misses special desc");
  endtask

  task automatic t_prio;
    wr(7, mk(3'd1, 0, 20'h12300, 20'hFFF00));
    route(32'h1234_5678, 0, "R5 lowest index wins");
    route(32'h1239_9000, 0, "R5 only higher matches");
  endtask

  task automatic t_same_cycle;
    logic eh; logic [IW-1:0] ei; logic [2:0] ep;
    wr(2, 64'h000000FF_FFF00000);
    route(32'h1234_5678, 0, "R8 after disable");
    // write re-enabling desc 2 and a request in one cycle
    expect_route(32'h1234_5678, 0, eh, ei, ep);
    @(negedge clk);
    reg_we = 1; reg_addr = AW'(RB + 2); reg_wdata = mk(3'd5, 0, 20'h12340, 20'hFFFF0);
    req_valid = 1; req_addr = 32'h1234_5678; req_special = 0;
    @(negedge clk);
    reg_we = 0; req_valid = 0;
    m_dst[2] = 3'd5; m_spc[2] = 0; m_base[2] = 20'h12340; m_mask[2] = 20'hFFFF0;
    chk("R8 same-cycle idx uses old", 64'(idx), 64'(ei));
    chk("R8 same-cycle port uses old", 64'(port), 64'(ep));
    route(32'h1234_5678, 0, "R8 next cycle uses new");
  endtask

  task automatic t_range;
    rd(RB + N, 64'd0, 1, "R10 read past end");
    rd(RB - 1, 64'd0, 1, "R10 read below base");
    wr(N, mk(3'd3, 0, 20'h0, 20'h0));
    wr(-1, mk(3'd3, 0, 20'h0, 20'h0));
    for (int i = 0; i < N; i++)
      rd(RB + i, mk(m_dst[i], m_spc[i], m_base[i], m_mask[i]), 0, "R10 oor write ignored");
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R7 no rsp without request", 64'(rsp_valid), 64'd0);
    chk("R11 no rvalid without read", 64'(reg_rvalid), 64'd0);
    chk("R11 err clears", 64'(reg_err), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_dst[i] = 0; m_spc[i] = 0; m_base[i] = 20'hFFFFF; m_mask[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_rsvd;
    t_match;
    t_special;
    t_prio;
    t_same_cycle;
    t_range;
    t_idle;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule